// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Arbiter

This block holds a small bank of hardware ownership flags that two independent agents, a left port and a right port, use to agree on who may touch a shared resource. To claim a flag, a port writes a 0 to it. It then reads the flag to learn the outcome. A read answers 0 to the port that holds the flag and 1 to anyone else. To give up a flag, its holder writes a 1.

Each port has a flag-select strobe, a write strobe, a read strobe, a flag address and a one-bit data input. It also has the enables of the neighbouring memory path, and these gate whether a flag access counts. All port operations take one clock cycle. Read data is registered and copied onto every line of a wide output bus. When both ports act on the same flag in one cycle, the left port's operation is applied first and the right port's operation is applied to that result. A simultaneous claim of a free flag therefore always goes to the left port, and both ports can never hold the same flag.

Top module: `sem_flag_arbiter`

## Requirements
- R1: A synchronous active-high reset frees all flags and drives every bit of both data outputs to 1.
- R2: A valid write of data 0 claims the addressed flag for that port when the flag is free or already held by that port. A later valid read of that flag then gives 0 to the holder and 1 to the other port.
- R3: A valid claim write of a flag held by the other port leaves the flag with its current holder.
- R4: All data-output bits of a port carry the same value after every read: all zeros or all ones.
- R5: An access counts as valid only when the port's flag select is 1 and either its memory enable is 0 or both of its byte enables are 0. A non-valid write changes no flag, and a non-valid read leaves the data output unchanged.
- R6: When both ports validly claim the same free flag in one cycle, the left port gets it. Reads of one flag by both ports in the same cycle never both return 0.
- R7: A valid write of data 1 by the holder frees the flag. The same write by the non-holder, or to a free flag, has no effect.
- R8: When the left port frees a flag and the right port claims it in the same cycle, the right port ends up holding it.
- R9: A read in the cycle right after a write to the same flag returns the new state. The data output changes one cycle after the read and holds its value in cycles without a valid read (a cycle with both write and read strobes counts as a write).
- R10: The flags at addresses 0 to 7 are independent. An operation on one flag changes no other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_sel | input | 1 | Left flag-space select |
| l_mem_en | input | 1 | Left memory-path enable (1 = memory selected) |
| l_byte_en | input | 2 | Left byte enables (1 = lane enabled) |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | 3 | Left flag address |
| l_din | input | 1 | Left write data (0 claims, 1 frees) |
| l_dout | output | 16 | Left read data, flag view on every bit |
| r_sem_sel | input | 1 | Right flag-space select |
| r_mem_en | input | 1 | Right memory-path enable |
| r_byte_en | input | 2 | Right byte enables |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | 3 | Right flag address |
| r_din | input | 1 | Right write data |
| r_dout | output | 16 | Right read data |

## Verification
Two pairs of operations can land in the same cycle: a claim by the left port and a claim by the right port on one free flag, and a free by the left holder together with a claim by the right port. The bench drives both ports in a single vector for each of these cases. It then reads the flag from both sides in the following cycle and expects exactly one port to see 0. Same-cycle reads of one flag by both ports are also issued, to confirm that the two answers always disagree while the flag is held.

// File: rtl/sem_arb_pkg.sv
package sem_arb_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  typedef struct packed {
    logic  held;
    side_e owner;
  } flag_t;
endpackage

// File: rtl/sem_access_decode.sv
module sem_access_decode #(
  parameter int NF = 8,
  localparam int AW = $clog2(NF)
) (
  input  logic          sem_sel,
  input  logic          mem_en,
  input  logic [1:0]    byte_en,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic [NF-1:0] req,
  output logic [NF-1:0] rel,
  output logic          rd_en
);
  logic valid;

  // Flag space is reachable only while the memory path is idle
  assign valid = sem_sel && (!mem_en || (byte_en == 2'b00));
  assign rd_en = valid && rd && !wr;

  for (genvar i = 0; i < NF; i++) begin : g_dec
    assign req[i] = valid && wr && !din && (addr == AW'(i));
    assign rel[i] = valid && wr &&  din && (addr == AW'(i));
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  l_req,
  input  logic  l_rel,
  input  logic  r_req,
  input  logic  r_rel,
  output flag_t state
);
  flag_t mid, nxt;

  // Left operation is applied first, right operation sees its result
  always_comb begin
    mid = state;
    if (l_req && (!state.held || state.owner == SIDE_L))
      mid = '{held: 1'b1, owner: SIDE_L};
    else if (l_rel && state.held && state.owner == SIDE_L)
      mid = '{held: 1'b0, owner: SIDE_L};

    nxt = mid;
    if (r_req && (!mid.held || mid.owner == SIDE_R))
      nxt = '{held: 1'b1, owner: SIDE_R};
    else if (r_rel && mid.held && mid.owner == SIDE_R)
      nxt = '{held: 1'b0, owner: SIDE_L};
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '{held: 1'b0, owner: SIDE_L};
    else     state <= nxt;
  end
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port
  import sem_arb_pkg::*;
#(
  parameter int    NF   = 8,
  parameter int    DW   = 16,
  parameter side_e SIDE = SIDE_L,
  localparam int   AW   = $clog2(NF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  flag_t [NF-1:0]    flags,
  output logic [DW-1:0]     dout
);
  logic view;

  assign view = !(flags[addr].held && flags[addr].owner == SIDE);

  always_ff @(posedge clk) begin
    if (rst)        dout <= '1;
    else if (rd_en) dout <= {DW{view}};
  end
endmodule

// File: rtl/sem_flag_arbiter.sv
module sem_flag_arbiter
  import sem_arb_pkg::*;
#(
  parameter int  NUM_FLAGS = 8,
  parameter int  DATA_W    = 16,
  localparam int AW        = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sem_sel,
  input  logic              l_mem_en,
  input  logic [1:0]        l_byte_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [AW-1:0]     l_addr,
  input  logic              l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              r_sem_sel,
  input  logic              r_mem_en,
  input  logic [1:0]        r_byte_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [AW-1:0]     r_addr,
  input  logic              r_din,
  output logic [DATA_W-1:0] r_dout
);
  logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic                 l_rd_en, r_rd_en;
  flag_t [NUM_FLAGS-1:0] flags;

  sem_access_decode #(.NF(NUM_FLAGS)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_en(l_mem_en), .byte_en(l_byte_en),
    .wr(l_wr), .rd(l_rd), .addr(l_addr), .din(l_din),
    .req(l_req), .rel(l_rel), .rd_en(l_rd_en)
  );

  sem_access_decode #(.NF(NUM_FLAGS)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_en(r_mem_en), .byte_en(r_byte_en),
    .wr(r_wr), .rd(r_rd), .addr(r_addr), .din(r_din),
    .req(r_req), .rel(r_rel), .rd_en(r_rd_en)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .state(flags[i])
    );
  end

  sem_read_port #(.NF(NUM_FLAGS), .DW(DATA_W), .SIDE(SIDE_L)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd_en), .addr(l_addr),
    .flags(flags), .dout(l_dout)
  );

  sem_read_port #(.NF(NUM_FLAGS), .DW(DATA_W), .SIDE(SIDE_R)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd_en), .addr(r_addr),
    .flags(flags), .dout(r_dout)
  );
endmodule

// File: rtl/sem_arb_checker.sv
module sem_arb_checker
  import sem_arb_pkg::*;
#(
  parameter int  NF = 8,
  parameter int  DW = 16,
  localparam int AW = $clog2(NF)
) (
  input logic          clk,
  input logic          rst,
  input logic          l_sem_sel,
  input logic          l_mem_en,
  input logic [1:0]    l_byte_en,
  input logic          l_wr,
  input logic          l_rd,
  input logic [AW-1:0] l_addr,
  input logic          l_din,
  input logic [DW-1:0] l_dout,
  input logic          r_sem_sel,
  input logic          r_mem_en,
  input logic [1:0]    r_byte_en,
  input logic          r_wr,
  input logic          r_rd,
  input logic [AW-1:0] r_addr,
  input logic          r_din,
  input logic [DW-1:0] r_dout,
  input flag_t [NF-1:0] flags
);
  logic l_ok, r_ok;
  assign l_ok = l_sem_sel && (!l_mem_en || l_byte_en == 2'b00);
  assign r_ok = r_sem_sel && (!r_mem_en || r_byte_en == 2'b00);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (l_dout == '1) && (r_dout == '1) && (flags == '0));

  p_uniform_r4: assert property (@(posedge clk) disable iff (rst)
    ((l_dout == '0) || (l_dout == '1)) && ((r_dout == '0) || (r_dout == '1)));

  p_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (!(l_ok && l_wr) && !(r_ok && r_wr)) |=> $stable(flags));

  p_tie_left_r6: assert property (@(posedge clk) disable iff (rst)
    (l_ok && l_wr && !l_din && r_ok && r_wr && !r_din &&
     l_addr == r_addr && !flags[l_addr].held)
    |=> flags[$past(l_addr)].held && flags[$past(l_addr)].owner == SIDE_L);

  p_never_both_r6: assert property (@(posedge clk) disable iff (rst)
    (l_ok && l_rd && !l_wr && r_ok && r_rd && !r_wr && l_addr == r_addr)
    |=> !(l_dout[0] == 1'b0 && r_dout[0] == 1'b0));

  p_foreign_release_r7: assert property (@(posedge clk) disable iff (rst)
    (l_ok && l_wr && l_din && flags[l_addr].held &&
     flags[l_addr].owner == SIDE_R && !(r_ok && r_wr && r_addr == l_addr))
    |=> flags[$past(l_addr)] == $past(flags[l_addr]));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(l_ok && l_rd && !l_wr) |=> $stable(l_dout));
endmodule

bind sem_flag_arbiter sem_arb_checker #(.NF(NUM_FLAGS), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_byte_en(l_byte_en),
  .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
  .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_byte_en(r_byte_en),
  .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout),
  .flags(flags)
);

// File: tb/sim_sem_flag_arbiter.sv
`timescale 1ns/1ps
module sim_sem_flag_arbiter;
  localparam int NF = 8;
  localparam int DW = 16;
  localparam int AW = $clog2(NF);
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst;
  logic l_sem_sel, l_mem_en, l_wr, l_rd, l_din;
  logic r_sem_sel, r_mem_en, r_wr, r_rd, r_din;
  logic [1:0] l_byte_en, r_byte_en;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_dout, r_dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sem_flag_arbiter #(.NUM_FLAGS(NF), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_byte_en(l_byte_en),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_byte_en(r_byte_en),
    .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout)
  );

  // {lop[13:12], laddr[11:9], ldin[8], rop[7:6], raddr[5:3], rdin[2], exp_l[1], exp_r[0]}
  // op: 0 idle, 1 write, 2 read; exp is the expected value of every dout bit
  localparam logic [13:0] VEC [NV] = '{
    {2'd1, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1}, // R2 left claims 0
    {2'd2, 3'd0, 1'b0, 2'd2, 3'd0, 1'b0, 1'b0, 1'b1}, // R2 R6 reads differ
    {2'd0, 3'd0, 1'b0, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1}, // R3 right claim fails
    {2'd2, 3'd0, 1'b0, 2'd2, 3'd0, 1'b0, 1'b0, 1'b1}, // R3
    {2'd0, 3'd0, 1'b0, 2'd1, 3'd0, 1'b1, 1'b0, 1'b1}, // R7 foreign release
    {2'd2, 3'd0, 1'b0, 2'd2, 3'd0, 1'b0, 1'b0, 1'b1}, // R7
    {2'd1, 3'd0, 1'b1, 2'd1, 3'd5, 1'b0, 1'b0, 1'b1}, // R7 owner frees, R10
    {2'd2, 3'd0, 1'b0, 2'd2, 3'd5, 1'b0, 1'b1, 1'b0}, // R7 R10
    {2'd1, 3'd3, 1'b0, 2'd1, 3'd3, 1'b0, 1'b1, 1'b0}, // R6 tie
    {2'd2, 3'd3, 1'b0, 2'd2, 3'd3, 1'b0, 1'b0, 1'b1}, // R6 left won
    {2'd1, 3'd3, 1'b1, 2'd1, 3'd3, 1'b0, 1'b0, 1'b1}, // R8 handover
    {2'd2, 3'd3, 1'b0, 2'd2, 3'd3, 1'b0, 1'b1, 1'b0}, // R8 right holds
    {2'd2, 3'd5, 1'b0, 2'd2, 3'd0, 1'b0, 1'b1, 1'b1}, // R10
    {2'd1, 3'd7, 1'b0, 2'd1, 3'd5, 1'b1, 1'b1, 1'b1}, // R7 R10
    {2'd2, 3'd7, 1'b0, 2'd2, 3'd5, 1'b0, 1'b0, 1'b1}  // R9 R10
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sem_sel = 0; l_mem_en = 0; l_byte_en = 0; l_wr = 0; l_rd = 0; l_addr = 0; l_din = 1;
    r_sem_sel = 0; r_mem_en = 0; r_byte_en = 0; r_wr = 0; r_rd = 0; r_addr = 0; r_din = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    tick(); tick();
    rst = 0;
    chk("R1 left reset", l_dout, '1);
    chk("R1 right reset", r_dout, '1);

    for (int i = 0; i < NV; i++) begin
      l_sem_sel = VEC[i][13:12] != 0; l_wr = VEC[i][13:12] == 1; l_rd = VEC[i][13:12] == 2;
      l_addr = VEC[i][11:9]; l_din = VEC[i][8];
      r_sem_sel = VEC[i][7:6] != 0; r_wr = VEC[i][7:6] == 1; r_rd = VEC[i][7:6] == 2;
      r_addr = VEC[i][5:3]; r_din = VEC[i][2];
      tick();
      chk($sformatf("R4 vec %0d left", i), l_dout, {DW{VEC[i][1]}});
      chk($sformatf("R4 vec %0d right", i), r_dout, {DW{VEC[i][0]}});
    end

    // R5: right claim blocked by memory enable with one byte lane active
    r_sem_sel = 1; r_mem_en = 1; r_byte_en = 2'b01; r_wr = 1; r_din = 0; r_addr = 4;
    tick();
    r_sem_sel = 1; r_rd = 1; r_addr = 4;
    tick();
    chk("R5 blocked claim ignored", r_dout, '1);
    // R5: left read blocked, left dout holds 0 from previous flag-7 read
    l_sem_sel = 1; l_mem_en = 1; l_byte_en = 2'b10; l_rd = 1; l_addr = 4;
    tick();
    chk("R5 blocked read holds", l_dout, '0);
    // R5: memory enable with both byte lanes off is valid
    r_sem_sel = 1; r_mem_en = 1; r_byte_en = 2'b00; r_wr = 1; r_din = 0; r_addr = 4;
    tick();
    r_sem_sel = 1; r_rd = 1; r_addr = 4;
    l_sem_sel = 1; l_rd = 1; l_addr = 4;
    tick();
    chk("R5 lanes-off claim right", r_dout, '0);
    chk("R5 lanes-off claim left", l_dout, '1);

    // R9: write then read next cycle; read in the write cycle sees old value
    l_sem_sel = 1; l_wr = 1; l_din = 0; l_addr = 6;
    r_sem_sel = 1; r_rd = 1; r_addr = 1;
    tick();
    l_sem_sel = 1; l_rd = 1; l_addr = 6;
    tick();
    chk("R9 read after write", l_dout, '0);
    tick();
    chk("R9 dout holds when idle", l_dout, '0);
    // R9: write and read strobes together count as write, dout unchanged
    l_sem_sel = 1; l_wr = 1; l_rd = 1; l_din = 1; l_addr = 6;
    tick();
    chk("R9 write-read cycle holds dout", l_dout, '0);
    l_sem_sel = 1; l_rd = 1; l_addr = 6;
    tick();
    chk("R9 R7 freed flag reads 1", l_dout, '1);

    // R3: left claim of flag 4 held by right fails
    l_sem_sel = 1; l_wr = 1; l_din = 0; l_addr = 4;
    tick();
    l_sem_sel = 1; l_rd = 1; l_addr = 4;
    r_sem_sel = 1; r_rd = 1; r_addr = 4;
    tick();
    chk("R3 left claim of held flag", l_dout, '1);
    chk("R3 right still holds", r_dout, '0);

    // R1: reset mid-run frees everything, R10 scan of all flags
    rst = 1;
    tick();
    rst = 0;
    chk("R1 mid-run reset left", l_dout, '1);
    chk("R1 mid-run reset right", r_dout, '1);
    for (int a = 0; a < NF; a++) begin
      l_sem_sel = 1; l_rd = 1; l_addr = AW'(a);
      r_sem_sel = 1; r_rd = 1; r_addr = AW'(a);
      tick();
      chk($sformatf("R1 R10 flag %0d free left", a), l_dout, '1);
      chk($sformatf("R1 R10 flag %0d free right", a), r_dout, '1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule